// File: doc/BRIEF.md
# Mailbox Message Transmit Controller

This block is the sending half of a small in-band mailbox channel. A local processor builds an eight-byte message in a buffer through a synchronous register port, then sets a send bit. While that bit is active, the block places the message into four fixed byte-slot pairs of every outgoing frame and raises a valid indication toward the far end. The slot number of the frame position being built comes in as an input. Frame timing, serialization and header checking are handled elsewhere.

The far-end receiver answers with a stop signal for flow control. When stop rises, the send bit is cleared, so valid drops. While stop stays high, the send bit cannot be set. When stop falls, the buffer becomes writable again and the ready flag returns. The processor can then assemble a new message, or send the old one again by setting send once more.

Top module: `mbx_tx_ctrl`

## Requirements
- R1: After reset, the ready flag reads 1, the send bit reads 0 and `link_valid` is 0. Register reads show the control word as 8'h02.
- R2: While ready is 1, a write to addresses 0..7 stores the byte at that index and leaves ready, send and `link_valid` unchanged. Bytes may be written in any order.
- R3: A control write (address 8) with bit 0 = 1 while `far_stop` is 0 sets send and `link_valid` one cycle later and clears ready.
- R4: While ready is 0, writes to addresses 0..7 are ignored and the buffer contents read back unchanged.
- R5: While `far_stop` is 1, send stays 0 and control writes cannot set it.
- R6: When `far_stop` rises, send clears and `link_valid` is 0 from the next cycle.
- R7: On the cycle after `far_stop` falls, ready is 1 and send is writable again. If a control write setting send lands in that same cycle, the write wins and ready stays 0.
- R8: `slot_num` values 13, 20, 41 and 48 map to message byte pairs (0,1), (2,3), (4,5) and (6,7). `slot_hit` and the pair appear on `slot_byte_first`/`slot_byte_second` one cycle after `slot_num`.
- R9: Both slot byte outputs are 8'h00 when send was 0 in the cycle the slot was sampled, and for every slot number outside the four.
- R10: `reg_rdata` is registered. One cycle after an address is presented, it shows buffer byte N for address N < 8, {6'b0, ready (bit 1), send (bit 0)} for address 8, and 0 for addresses 9..15.
- R11: A control write with bit 0 = 0 clears send without setting ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register address: 0..7 buffer, 8 control |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for `reg_addr` |
| far_stop | input | 1 | Stop request from the far-end receiver |
| slot_num | input | 6 | Slot number of the frame position being built |
| link_valid | output | 1 | Valid indication toward the far end (send bit) |
| slot_hit | output | 1 | The sampled slot carries message bytes |
| slot_byte_first | output | 8 | First byte for the sampled slot |
| slot_byte_second | output | 8 | Second byte for the sampled slot |

## Verification
The bench targets four cases.

- A buffer write attempted while a send is in flight. A design that did not gate writes with ready would let the message change in mid-air.
- A control write setting send while stop is high. A faulty design would raise valid against the far end's wishes.
- A control write setting send in the same cycle that stop falls. A design that let the stop edge win would leave ready set with send active.
- A full slot sweep with and without send. A wrong slot table or a missing null fill would put bytes in the wrong positions or leak stale message data.

// File: rtl/mbx_tx_pkg.sv
// Package: shared widths, register map and slot table for the mailbox transmitter.
// Assumes a message of an even number of bytes, carried two bytes per slot.
package mbx_tx_pkg;
    parameter int BYTE_W    = 8;
    parameter int MSG_BYTES = 8;
    parameter int ADDR_W    = 4;
    parameter int SLOT_W    = 6;
    parameter int NUM_SLOTS = MSG_BYTES / 2;
    parameter int CTRL_ADDR = MSG_BYTES;
    parameter int SEND_BIT  = 0;
    parameter int READY_BIT = 1;

    // Slot number that carries byte pair idx.
    function automatic int slot_of(input int idx);
        case (idx)
            0:       return 13;
            1:       return 20;
            2:       return 41;
            default: return 48;
        endcase
    endfunction
endpackage

// File: rtl/mbx_tx_msgbuf.sv
// Module: message buffer of MSG_BYTES registers, writable only when allowed.
// Assumes addresses at or above MSG_BYTES never select a buffer byte.
module mbx_tx_msgbuf #(
    parameter int BYTE_W    = mbx_tx_pkg::BYTE_W,
    parameter int MSG_BYTES = mbx_tx_pkg::MSG_BYTES,
    parameter int ADDR_W    = mbx_tx_pkg::ADDR_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        wr_allow,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [BYTE_W-1:0]           wdata,
    output logic [MSG_BYTES*BYTE_W-1:0] msg_flat,
    output logic [BYTE_W-1:0]           rd_byte
);
    logic [BYTE_W-1:0] bytes_q [MSG_BYTES];

    for (genvar gi = 0; gi < MSG_BYTES; gi++) begin : g_byte
        // Store one buffer byte on an allowed write to its address.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bytes_q[gi] <= '0;
            end else if (wr_en && wr_allow && (addr == ADDR_W'(gi))) begin
                bytes_q[gi] <= wdata;
            end
        end
        assign msg_flat[gi*BYTE_W +: BYTE_W] = bytes_q[gi];
    end

    // Select the addressed byte for the read path.
    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < MSG_BYTES; i++) begin
            if (addr == ADDR_W'(i)) rd_byte = bytes_q[i];
        end
    end
endmodule

// File: rtl/mbx_tx_flow.sv
// Module: ready/send flow control driven by processor writes and far-end stop.
// Assumes far_stop is already synchronous to clk.
module mbx_tx_flow (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic send_wdata,
    input  logic far_stop,
    output logic ready,
    output logic send
);
    logic stop_q;
    logic stop_fell;
    logic send_accept;

    assign stop_fell   = stop_q && !far_stop;
    assign send_accept = ctrl_wr && send_wdata && !far_stop;

    // Remember the previous stop level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) stop_q <= 1'b0;
        else        stop_q <= far_stop;
    end

    // Send bit: held clear under stop, otherwise follows control writes.
    always_ff @(posedge clk) begin
        if (!rst_n)        send <= 1'b0;
        else if (far_stop) send <= 1'b0;
        else if (ctrl_wr)  send <= send_wdata;
    end

    // Ready flag: cleared by an accepted send, set again when stop falls.
    always_ff @(posedge clk) begin
        if (!rst_n)           ready <= 1'b1;
        else if (send_accept) ready <= 1'b0;
        else if (stop_fell)   ready <= 1'b1;
    end
endmodule

// File: rtl/mbx_tx_slot_mux.sv
// Module: places message byte pairs into their fixed frame slots, null otherwise.
// Assumes each slot number appears at most once in the slot table.
module mbx_tx_slot_mux #(
    parameter int BYTE_W    = mbx_tx_pkg::BYTE_W,
    parameter int MSG_BYTES = mbx_tx_pkg::MSG_BYTES,
    parameter int SLOT_W    = mbx_tx_pkg::SLOT_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SLOT_W-1:0]           slot_num,
    input  logic                        send,
    input  logic [MSG_BYTES*BYTE_W-1:0] msg_flat,
    output logic                        hit,
    output logic [BYTE_W-1:0]           byte_first,
    output logic [BYTE_W-1:0]           byte_second
);
    localparam int NUM_SLOTS = MSG_BYTES / 2;
    localparam int PAIR_W    = 2 * BYTE_W;

    logic [NUM_SLOTS-1:0] match;
    logic [PAIR_W-1:0]    pair_sel;

    for (genvar gs = 0; gs < NUM_SLOTS; gs++) begin : g_slot
        assign match[gs] = (slot_num == SLOT_W'(mbx_tx_pkg::slot_of(gs)));
    end

    // OR together the byte pair of the matching slot.
    always_comb begin
        pair_sel = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (match[i]) pair_sel = pair_sel | msg_flat[i*PAIR_W +: PAIR_W];
        end
    end

    // Register the slot outputs, null-filled unless send is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit         <= 1'b0;
            byte_first  <= '0;
            byte_second <= '0;
        end else begin
            hit         <= |match;
            byte_first  <= send ? pair_sel[BYTE_W-1:0]      : '0;
            byte_second <= send ? pair_sel[PAIR_W-1:BYTE_W] : '0;
        end
    end
endmodule

// File: rtl/mbx_tx_ctrl.sv
// Module: top of the mailbox transmitter; register port, flow control, slot insertion.
// Assumes a synchronous register port with one-cycle registered read data.
module mbx_tx_ctrl #(
    parameter int BYTE_W    = mbx_tx_pkg::BYTE_W,
    parameter int MSG_BYTES = mbx_tx_pkg::MSG_BYTES,
    parameter int ADDR_W    = mbx_tx_pkg::ADDR_W,
    parameter int SLOT_W    = mbx_tx_pkg::SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              far_stop,
    input  logic [SLOT_W-1:0] slot_num,
    output logic              link_valid,
    output logic              slot_hit,
    output logic [BYTE_W-1:0] slot_byte_first,
    output logic [BYTE_W-1:0] slot_byte_second
);
    localparam int CTRL_ADDR = MSG_BYTES;

    logic                        ready_w;
    logic                        send_w;
    logic                        ctrl_sel;
    logic                        buf_sel;
    logic [MSG_BYTES*BYTE_W-1:0] msg_flat;
    logic [BYTE_W-1:0]           buf_rd;
    logic [BYTE_W-1:0]           ctrl_word;

    assign ctrl_sel = (reg_addr == ADDR_W'(CTRL_ADDR));
    assign buf_sel  = (reg_addr < ADDR_W'(MSG_BYTES));

    mbx_tx_msgbuf #(.BYTE_W(BYTE_W), .MSG_BYTES(MSG_BYTES), .ADDR_W(ADDR_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en && buf_sel),
        .wr_allow (ready_w),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .msg_flat (msg_flat),
        .rd_byte  (buf_rd)
    );

    mbx_tx_flow u_flow (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (reg_wr_en && ctrl_sel),
        .send_wdata (reg_wdata[mbx_tx_pkg::SEND_BIT]),
        .far_stop   (far_stop),
        .ready      (ready_w),
        .send       (send_w)
    );

    mbx_tx_slot_mux #(.BYTE_W(BYTE_W), .MSG_BYTES(MSG_BYTES), .SLOT_W(SLOT_W)) u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_num    (slot_num),
        .send        (send_w),
        .msg_flat    (msg_flat),
        .hit         (slot_hit),
        .byte_first  (slot_byte_first),
        .byte_second (slot_byte_second)
    );

    // Assemble the control word from the flow-control state.
    always_comb begin
        ctrl_word = '0;
        ctrl_word[mbx_tx_pkg::SEND_BIT]  = send_w;
        ctrl_word[mbx_tx_pkg::READY_BIT] = ready_w;
    end

    // Register the read data for the presented address.
    always_ff @(posedge clk) begin
        if (!rst_n)        reg_rdata <= '0;
        else if (buf_sel)  reg_rdata <= buf_rd;
        else if (ctrl_sel) reg_rdata <= ctrl_word;
        else               reg_rdata <= '0;
    end

    assign link_valid = send_w;
endmodule

// File: rtl/mbx_tx_ctrl_chk.sv
// Checker: temporal properties of the mailbox transmitter, bound to the top.
module mbx_tx_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] reg_addr,
    input logic       reg_wr_en,
    input logic [7:0] reg_wdata,
    input logic       far_stop,
    input logic       link_valid,
    input logic       ready,
    input logic [7:0] slot_byte_first,
    input logic [7:0] slot_byte_second
);
    logic send_wr;
    assign send_wr = reg_wr_en && (reg_addr == 4'd8) && reg_wdata[0];

    p_send_sets_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (send_wr && !far_stop) |=> (link_valid && !ready));

    p_buf_write_keeps_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && (reg_addr < 4'd8) && !far_stop) |=> $stable(link_valid));

    p_stop_blocks_send_r5: assert property (@(posedge clk) disable iff (!rst_n)
        far_stop |=> !link_valid);

    p_ready_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(far_stop) && !send_wr) |=> ready);

    p_null_filler_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !link_valid |=> (slot_byte_first == 8'h00 && slot_byte_second == 8'h00));
endmodule

bind mbx_tx_ctrl mbx_tx_ctrl_chk chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .reg_addr         (reg_addr),
    .reg_wr_en        (reg_wr_en),
    .reg_wdata        (reg_wdata),
    .far_stop         (far_stop),
    .link_valid       (link_valid),
    .ready            (ready_w),
    .slot_byte_first  (slot_byte_first),
    .slot_byte_second (slot_byte_second)
);

// File: tb/mbx_tx_ctrl_tb_top.sv
// Bench: behavioural reference model compared on every clock, plus directed checks.
module mbx_tx_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       far_stop = 1'b0;
    logic [5:0] slot_num = '0;
    logic       link_valid;
    logic       slot_hit;
    logic [7:0] slot_byte_first;
    logic [7:0] slot_byte_second;

    int checks = 0;
    int errors = 0;

    // Reference model state.
    int m_ready, m_send, m_stop_q, m_rdata, m_hit, m_first, m_second;
    int m_buf [8];

    always #4 clk = ~clk;

    mbx_tx_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .far_stop(far_stop),
        .slot_num(slot_num), .link_valid(link_valid), .slot_hit(slot_hit),
        .slot_byte_first(slot_byte_first), .slot_byte_second(slot_byte_second)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Behavioural model advanced at each rising edge from pre-edge inputs.
    always @(posedge clk) begin
        int a, pair, n_ready, n_send;
        if (!rst_n) begin
            m_ready = 1; m_send = 0; m_stop_q = 0; m_rdata = 0;
            m_hit = 0; m_first = 0; m_second = 0;
            foreach (m_buf[i]) m_buf[i] = 0;
        end else begin
            a = int'(reg_addr);
            if (a < 8) m_rdata = m_buf[a];
            else if (a == 8) m_rdata = m_ready * 2 + m_send;
            else m_rdata = 0;
            case (int'(slot_num))
                13: pair = 0;
                20: pair = 1;
                41: pair = 2;
                48: pair = 3;
                default: pair = -1;
            endcase
            m_hit = (pair >= 0);
            m_first  = (pair >= 0 && m_send == 1) ? m_buf[2*pair]   : 0;
            m_second = (pair >= 0 && m_send == 1) ? m_buf[2*pair+1] : 0;
            n_ready = m_ready; n_send = m_send;
            if (far_stop) n_send = 0;
            else if (reg_wr_en && a == 8) n_send = int'(reg_wdata[0]);
            if (reg_wr_en && a == 8 && reg_wdata[0] && !far_stop) n_ready = 0;
            else if (m_stop_q == 1 && !far_stop) n_ready = 1;
            if (reg_wr_en && a < 8 && m_ready == 1) m_buf[a] = int'(reg_wdata);
            m_ready = n_ready; m_send = n_send; m_stop_q = int'(far_stop);
        end
    end

    // Compare every output with the model in the middle of each cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(int'(link_valid) == m_send, "R3/R5/R6 link_valid", int'(link_valid), m_send);
            chk(int'(reg_rdata) == m_rdata, "R10 reg_rdata", int'(reg_rdata), m_rdata);
            chk(int'(slot_hit) == m_hit, "R8 slot_hit", int'(slot_hit), m_hit);
            chk(int'(slot_byte_first) == m_first, "R8/R9 slot_byte_first", int'(slot_byte_first), m_first);
            chk(int'(slot_byte_second) == m_second, "R8/R9 slot_byte_second", int'(slot_byte_second), m_second);
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_addr = 4'(a); reg_wdata = 8'(d); reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        reg_addr = 4'(a); reg_wr_en = 1'b0;
        @(negedge clk);
        d = int'(reg_rdata);
    endtask

    task automatic sweep();
        for (int s = 0; s < 64; s++) begin
            @(negedge clk);
            slot_num = 6'(s);
        end
        @(negedge clk);
    endtask

    task automatic slot_at(input int s, output int f, output int sc);
        @(negedge clk);
        slot_num = 6'(s);
        @(negedge clk);
        f = int'(slot_byte_first); sc = int'(slot_byte_second);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v, f, s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        rd(8, v);
        chk(v == 8'h02, "R1 ctrl after reset", v, 8'h02);
        chk(link_valid == 1'b0, "R1 valid after reset", int'(link_valid), 0);
        // R2: out-of-order buffer writes, readback.
        wr(5, 8'h55); wr(0, 8'hA0); wr(7, 8'h77); wr(2, 8'h22);
        wr(1, 8'hA1); wr(6, 8'h66); wr(3, 8'h33); wr(4, 8'h44);
        rd(5, v); chk(v == 8'h55, "R2 readback byte5", v, 8'h55);
        rd(0, v); chk(v == 8'hA0, "R2 readback byte0", v, 8'hA0);
        rd(8, v); chk(v == 8'h02, "R2 ctrl unchanged", v, 8'h02);
        rd(12, v); chk(v == 0, "R10 unmapped address", v, 0);
        // R9: null filler while not sending.
        sweep();
        slot_at(13, f, s); chk(f == 0 && s == 0, "R9 null while idle", f, 0);
        // R3: set send.
        wr(8, 1);
        chk(link_valid == 1'b1, "R3 valid after send", int'(link_valid), 1);
        rd(8, v); chk(v == 8'h01, "R3 ready cleared", v, 8'h01);
        // R4: buffer write ignored while not ready.
        wr(2, 8'hEE);
        rd(2, v); chk(v == 8'h22, "R4 write ignored", v, 8'h22);
        // R8: slot mapping across two frames.
        sweep(); sweep();
        slot_at(13, f, s); chk(f == 8'hA0 && s == 8'hA1, "R8 slot13", f, 8'hA0);
        slot_at(20, f, s); chk(f == 8'h22 && s == 8'h33, "R8 slot20", f, 8'h22);
        slot_at(41, f, s); chk(f == 8'h44 && s == 8'h55, "R8 slot41", f, 8'h44);
        slot_at(48, f, s); chk(f == 8'h66 && s == 8'h77, "R8 slot48", f, 8'h66);
        slot_at(14, f, s); chk(f == 0 && s == 0, "R9 non-slot", f, 0);
        // R11: clearing send keeps ready low, then resend.
        wr(8, 0);
        rd(8, v); chk(v == 8'h00, "R11 clear send", v, 0);
        wr(8, 1);
        chk(link_valid == 1'b1, "R11 resend", int'(link_valid), 1);
        // R6: stop rises.
        @(negedge clk); far_stop = 1'b1;
        @(negedge clk);
        chk(link_valid == 1'b0, "R6 valid drop", int'(link_valid), 0);
        // R5: send cannot be set while stopped.
        wr(8, 1);
        chk(link_valid == 1'b0, "R5 send blocked", int'(link_valid), 0);
        rd(8, v); chk(v == 8'h00, "R5 ctrl while stopped", v, 0);
        // R7: stop falls, ready returns, new message sent.
        @(negedge clk); far_stop = 1'b0;
        rd(8, v); chk(v == 8'h02, "R7 ready after fall", v, 8'h02);
        wr(0, 8'h5A);
        wr(8, 1);
        slot_at(13, f, s); chk(f == 8'h5A && s == 8'hA1, "R7 new message", f, 8'h5A);
        // R7: write and stop fall in the same cycle, write wins.
        @(negedge clk); far_stop = 1'b1;
        @(negedge clk);
        reg_addr = 4'd8; reg_wdata = 8'h01; reg_wr_en = 1'b1; far_stop = 1'b0;
        @(negedge clk); reg_wr_en = 1'b0;
        rd(8, v); chk(v == 8'h01, "R7 write wins on fall", v, 8'h01);
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule